// File: doc/BRIEF.md
# Clock Buffer Power and Lock Sequencer

This block steps a differential clock buffer from supply-off to normal running. Once the supply is good it waits a fixed startup delay counted on a free-running timebase. It then waits for a valid input clock and a locked PLL, and only then enables the outputs. At that moment it also raises a lock indicator. The indicator is sticky: later changes in PLL status do not affect it. Only a recognised power-down request or a loss of supply clears it.

The active-low power-down pin is debounced. A request is recognised only when the pin reads low on two consecutive clock edges, and a release only when it reads high on two consecutive edges. While powered down, every output pair is parked in one of two ways, chosen by a drive-mode bit. Mode 0 drives the true leg high and floats the complement leg. Mode 1 floats both legs. After a release the sequencer goes back to waiting for input clock and lock.

The PLL, the supply detector and the input-clock detector sit outside the block and appear only as flags.

Top module: `pwr_lock_seq`

## Requirements
- R1: While `rstN` is low, and in the power-off state, `seqState` is 0, `lockOut` and `outEnable` are 0, and every leg floats. For every leg, `floatTrue`=1, `floatComp`=1 and `parkTrueHigh`=0.
- R2: With `supplyGood` high in power-off, the next edge enters the startup-delay state (code 1). The state stays there for exactly `DELAY_CYCLES` clock cycles and then moves to the wait state (code 2).
- R3: In the wait state, if `inClkValid` or `pllLocked` is low, the state stays at 2 and `outEnable` stays 0.
- R4: In the wait state with both `inClkValid` and `pllLocked` high, the next edge enters the run state (code 3) and sets `lockOut`. `outEnable` is 1 exactly while the state is 3, and in that state no leg is floated or parked.
- R5: In the run state, changes on `pllLocked` or `inClkValid` alter neither `lockOut` nor the state.
- R6: In the wait or run state, a power-down request is recognised at the second of two consecutive edges that sample `pwrDownN` low. The state becomes 4 and `lockOut` clears. A low lasting a single edge has no effect.
- R7: In state 4, with `pdTristate`=0 every leg has `parkTrueHigh`=1, `floatTrue`=0 and `floatComp`=1. With `pdTristate`=1 every leg has `parkTrueHigh`=0 and both float bits set.
- R8: In state 4, the state returns to 2 at the second of two consecutive edges that sample `pwrDownN` high. Lock must then be acquired again as in R4.
- R9: From any state, `supplyGood` low at an edge forces state 0 and clears `lockOut` at that edge.
- R10: During the startup delay, `pwrDownN` has no effect. If the pin is still low when the delay ends, the wait state then enters state 4 as R6 describes.
- R11: Outside states 3 and 4, every leg floats both its true and complement sides, with `parkTrueHigh`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running timebase and sampling clock |
| rstN | input | 1 | Asynchronous active-low reset |
| supplyGood | input | 1 | Supply above threshold |
| inClkValid | input | 1 | Valid reference clock present |
| pllLocked | input | 1 | PLL lock status |
| pwrDownN | input | 1 | Active-low power-down pin |
| pdTristate | input | 1 | Power-down park mode: 0 true high, 1 both float |
| seqState | output | 3 | Sequencer state code (0..4) |
| lockOut | output | 1 | Sticky lock indicator |
| outEnable | output | 1 | Global output enable |
| parkTrueHigh | output | NUM_OUT | Per pair: hold true leg high |
| floatTrue | output | NUM_OUT | Per pair: float true leg |
| floatComp | output | NUM_OUT | Per pair: float complement leg |

## Verification
Directed sequences cover the full power-up path, with the delay boundary checked cycle by cycle. Lock acquisition is tried with input clock and PLL lock each missing in turn, so a design that needs only one of them is caught. Power-down is tried with a one-edge glitch, a held low, a release interrupted by a low, a request made during the startup delay, and both park modes. These separate real debouncing from single-sample decoding. A long random phase then drops supply, toggles the pin and flips the flags at mixed rates, against a cycle model derived from the requirements.

// File: rtl/pwr_lock_seq_pkg.sv
package pwr_lock_seq_pkg;

  typedef enum logic [2:0] {
    S_OFF   = 3'd0,
    S_DELAY = 3'd1,
    S_WAIT  = 3'd2,
    S_RUN   = 3'd3,
    S_PDOWN = 3'd4
  } seqState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic cntClr;
    logic cntRun;
    logic lockSet;
    logic lockClr;
  } seqStrobe_t;

  // status from datapath back to control
  typedef struct packed {
    logic delayDone;
    logic pdAsserted;
    logic pdReleased;
  } seqStatus_t;

endpackage

// File: rtl/pwr_lock_seq_ctrl.sv
module pwr_lock_seq_ctrl
  import pwr_lock_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       supplyGood,
  input  logic       inClkValid,
  input  logic       pllLocked,
  input  seqStatus_t stat,
  output seqState_e  curState,
  output seqStrobe_t strb
);

  seqState_e nextState;

  always_comb begin
    nextState = curState;
    strb      = '0;
    if (!supplyGood) begin
      nextState    = S_OFF;
      strb.lockClr = 1'b1;
      strb.cntClr  = 1'b1;
    end else begin
      unique case (curState)
        S_OFF: begin
          nextState   = S_DELAY;
          strb.cntClr = 1'b1;
        end
        S_DELAY: begin
          if (stat.delayDone) nextState = S_WAIT;
          else                strb.cntRun = 1'b1;
        end
        S_WAIT: begin
          if (stat.pdAsserted) begin
            nextState    = S_PDOWN;
            strb.lockClr = 1'b1;
          end else if (inClkValid && pllLocked) begin
            nextState    = S_RUN;
            strb.lockSet = 1'b1;
          end
        end
        S_RUN: begin
          if (stat.pdAsserted) begin
            nextState    = S_PDOWN;
            strb.lockClr = 1'b1;
          end
        end
        S_PDOWN: begin
          if (stat.pdReleased) nextState = S_WAIT;
        end
        default: nextState = S_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) curState <= S_OFF;
    else       curState <= nextState;
  end

endmodule

// File: rtl/pwr_lock_seq_dp.sv
module pwr_lock_seq_dp
  import pwr_lock_seq_pkg::*;
#(
  parameter int NUM_OUT      = 8,
  parameter int DELAY_CYCLES = 25000
) (
  input  logic               clk,
  input  logic               rstN,
  input  seqStrobe_t         strb,
  input  seqState_e          curState,
  input  logic               pwrDownN,
  input  logic               pdTristate,
  output seqStatus_t         stat,
  output logic               lockOut,
  output logic               outEnable,
  output logic [NUM_OUT-1:0] parkTrueHigh,
  output logic [NUM_OUT-1:0] floatTrue,
  output logic [NUM_OUT-1:0] floatComp
);

  localparam int CNT_W = $clog2(DELAY_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DELAY_CYCLES - 1);

  logic [CNT_W-1:0] delayCnt;
  logic             pinPrev;

  // startup delay counter on the free-running timebase
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            delayCnt <= '0;
    else if (strb.cntClr) delayCnt <= '0;
    else if (strb.cntRun) delayCnt <= delayCnt + 1'b1;
  end

  // two-sample debounce of the power-down pin
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pinPrev <= 1'b1;
    else       pinPrev <= pwrDownN;
  end

  // sticky lock flag
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             lockOut <= 1'b0;
    else if (strb.lockClr) lockOut <= 1'b0;
    else if (strb.lockSet) lockOut <= 1'b1;
  end

  always_comb begin
    stat.delayDone  = (delayCnt == CNT_LAST);
    stat.pdAsserted = !pwrDownN && !pinPrev;
    stat.pdReleased = pwrDownN && pinPrev;
  end

  assign outEnable = (curState == S_RUN);

  logic legHigh, legFloatT, legFloatC;

  always_comb begin
    unique case (curState)
      S_RUN: begin
        legHigh = 1'b0; legFloatT = 1'b0; legFloatC = 1'b0;
      end
      S_PDOWN: begin
        legHigh = !pdTristate; legFloatT = pdTristate; legFloatC = 1'b1;
      end
      default: begin
        legHigh = 1'b0; legFloatT = 1'b1; legFloatC = 1'b1;
      end
    endcase
  end

  for (genvar g = 0; g < NUM_OUT; g++) begin : g_leg
    assign parkTrueHigh[g] = legHigh;
    assign floatTrue[g]    = legFloatT;
    assign floatComp[g]    = legFloatC;
  end

endmodule

// File: rtl/pwr_lock_seq.sv
module pwr_lock_seq
  import pwr_lock_seq_pkg::*;
#(
  parameter int NUM_OUT      = 8,
  parameter int DELAY_CYCLES = 25000
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               supplyGood,
  input  logic               inClkValid,
  input  logic               pllLocked,
  input  logic               pwrDownN,
  input  logic               pdTristate,
  output logic [2:0]         seqState,
  output logic               lockOut,
  output logic               outEnable,
  output logic [NUM_OUT-1:0] parkTrueHigh,
  output logic [NUM_OUT-1:0] floatTrue,
  output logic [NUM_OUT-1:0] floatComp
);

  seqState_e  curState;
  seqStrobe_t strb;
  seqStatus_t stat;

  pwr_lock_seq_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .supplyGood (supplyGood),
    .inClkValid (inClkValid),
    .pllLocked  (pllLocked),
    .stat       (stat),
    .curState   (curState),
    .strb       (strb)
  );

  pwr_lock_seq_dp #(
    .NUM_OUT      (NUM_OUT),
    .DELAY_CYCLES (DELAY_CYCLES)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .curState     (curState),
    .pwrDownN     (pwrDownN),
    .pdTristate   (pdTristate),
    .stat         (stat),
    .lockOut      (lockOut),
    .outEnable    (outEnable),
    .parkTrueHigh (parkTrueHigh),
    .floatTrue    (floatTrue),
    .floatComp    (floatComp)
  );

  assign seqState = curState;

endmodule

// File: rtl/pwr_lock_seq_chk.sv
module pwr_lock_seq_chk #(
  parameter int NUM_OUT = 8
) (
  input logic               clk,
  input logic               rstN,
  input logic               supplyGood,
  input logic               inClkValid,
  input logic               pllLocked,
  input logic               pwrDownN,
  input logic               pdTristate,
  input logic [2:0]         seqState,
  input logic               lockOut,
  input logic               outEnable,
  input logic [NUM_OUT-1:0] parkTrueHigh,
  input logic [NUM_OUT-1:0] floatTrue,
  input logic [NUM_OUT-1:0] floatComp
);

  // R4
  lock_only_in_run_chk: assert property (@(posedge clk) disable iff (!rstN)
    lockOut |-> (seqState == 3'd3));

  // R2
  off_to_delay_chk: assert property (@(posedge clk) disable iff (!rstN)
    (seqState == 3'd0 && supplyGood) |=> (seqState == 3'd1));

  // R3
  wait_holds_chk: assert property (@(posedge clk) disable iff (!rstN)
    (seqState == 3'd2 && supplyGood && pwrDownN && !(inClkValid && pllLocked))
      |=> (seqState == 3'd2 && !outEnable));

  // R5
  run_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (seqState == 3'd3 && supplyGood && pwrDownN) |=> (seqState == 3'd3 && lockOut));

  // R9
  supply_loss_chk: assert property (@(posedge clk) disable iff (!rstN)
    !supplyGood |=> (seqState == 3'd0 && !lockOut));

  // R7
  park_driven_chk: assert property (@(posedge clk) disable iff (!rstN)
    (seqState == 3'd4 && !pdTristate)
      |-> (&parkTrueHigh && &floatComp && !(|floatTrue) && !outEnable));

  // R7
  park_float_chk: assert property (@(posedge clk) disable iff (!rstN)
    (seqState == 3'd4 && pdTristate)
      |-> (!(|parkTrueHigh) && &floatComp && &floatTrue));

endmodule

bind pwr_lock_seq pwr_lock_seq_chk #(.NUM_OUT(NUM_OUT)) u_chk (.*);

// File: tb/pwr_lock_seq_bench.sv
module pwr_lock_seq_bench;

  localparam int NOUT = 4;
  localparam int DLY  = 40;

  logic clk = 1'b0;
  logic rstN, supplyGood, inClkValid, pllLocked, pwrDownN, pdTristate;
  logic [2:0] seqState;
  logic lockOut, outEnable;
  logic [NOUT-1:0] parkTrueHigh, floatTrue, floatComp;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  pwr_lock_seq #(.NUM_OUT(NOUT), .DELAY_CYCLES(DLY)) u_pwr_lock_seq (
    .clk(clk), .rstN(rstN), .supplyGood(supplyGood), .inClkValid(inClkValid),
    .pllLocked(pllLocked), .pwrDownN(pwrDownN), .pdTristate(pdTristate),
    .seqState(seqState), .lockOut(lockOut), .outEnable(outEnable),
    .parkTrueHigh(parkTrueHigh), .floatTrue(floatTrue), .floatComp(floatComp)
  );

  // reference model built from the requirements
  logic [2:0] mState;
  logic       mLock, mPrev;
  int         mCnt;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mState <= 3'd0; mLock <= 1'b0; mPrev <= 1'b1; mCnt <= 0;
    end else begin
      mPrev <= pwrDownN;
      if (!supplyGood) begin
        mState <= 3'd0; mLock <= 1'b0;
      end else begin
        case (mState)
          3'd0: begin mState <= 3'd1; mCnt <= 1; end
          3'd1: if (mCnt == DLY) mState <= 3'd2; else mCnt <= mCnt + 1;
          3'd2: if (!pwrDownN && !mPrev) begin mState <= 3'd4; mLock <= 1'b0; end
                else if (inClkValid && pllLocked) begin mState <= 3'd3; mLock <= 1'b1; end
          3'd3: if (!pwrDownN && !mPrev) begin mState <= 3'd4; mLock <= 1'b0; end
          3'd4: if (pwrDownN && mPrev) mState <= 3'd2;
          default: mState <= 3'd0;
        endcase
      end
    end
  end

  function automatic logic [2:0] expLegs(input logic [2:0] st, input logic mode);
    // {parkTrueHigh, floatTrue, floatComp}
    if (st == 3'd3)      return 3'b000;
    else if (st == 3'd4) return {!mode, mode, 1'b1};
    else                 return 3'b011;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic cyc(input string tag);
    logic [2:0] legs;
    @(negedge clk);
    legs = expLegs(mState, pdTristate);
    check(tag, 32'(seqState), 32'(mState), "state");
    check(tag, 32'(lockOut), 32'(mLock), "lock");
    check(tag, 32'(outEnable), 32'(mState == 3'd3), "outEnable");
    check(tag, 32'(parkTrueHigh), 32'({NOUT{legs[2]}}), "parkTrueHigh");
    check(tag, 32'(floatTrue), 32'({NOUT{legs[1]}}), "floatTrue");
    check(tag, 32'(floatComp), 32'({NOUT{legs[0]}}), "floatComp");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    rstN = 0; supplyGood = 0; inClkValid = 0; pllLocked = 0;
    pwrDownN = 1; pdTristate = 0;
    repeat (3) cyc("R1");
    rstN = 1;
    repeat (3) cyc("R1");
    // power-up and delay boundary
    supplyGood = 1;
    repeat (DLY + 2) cyc("R2");
    check("R2", 32'(seqState), 32'd2, "state after delay");
    // missing input clock, then missing lock
    pllLocked = 1;
    repeat (4) cyc("R3");
    inClkValid = 1; pllLocked = 0;
    repeat (3) cyc("R3");
    pllLocked = 1;
    cyc("R4");
    check("R4", 32'(lockOut), 32'd1, "lock at run entry");
    // lock is sticky
    pllLocked = 0; inClkValid = 0;
    repeat (4) cyc("R5");
    // one-edge glitch ignored
    pwrDownN = 0; cyc("R6");
    pwrDownN = 1; repeat (3) cyc("R6");
    check("R6", 32'(seqState), 32'd3, "glitch ignored");
    // held low, park driven
    pwrDownN = 0;
    repeat (3) cyc("R7");
    check("R6", 32'(seqState), 32'd4, "powered down");
    pdTristate = 1; repeat (2) cyc("R7");
    // interrupted release
    pwrDownN = 1; cyc("R8");
    pwrDownN = 0; cyc("R8");
    check("R8", 32'(seqState), 32'd4, "release interrupted");
    pwrDownN = 1; repeat (2) cyc("R8");
    check("R8", 32'(seqState), 32'd2, "released to wait");
    inClkValid = 1; pllLocked = 1;
    cyc("R4");
    // supply loss
    supplyGood = 0; cyc("R9");
    check("R9", 32'(lockOut), 32'd0, "lock cleared on supply loss");
    // request during delay
    supplyGood = 1; pwrDownN = 0;
    repeat (DLY + 4) cyc("R10");
    check("R10", 32'(seqState), 32'd4, "delayed request honoured");
    pwrDownN = 1; repeat (3) cyc("R11");
    // random phase
    for (int i = 0; i < 4000; i++) begin
      if (($urandom % 64) == 0) supplyGood = ~supplyGood;
      if (($urandom % 6) == 0)  pwrDownN = ~pwrDownN;
      if (($urandom % 5) == 0)  inClkValid = $urandom;
      if (($urandom % 5) == 0)  pllLocked = $urandom;
      if (($urandom % 9) == 0)  pdTristate = $urandom;
      cyc("R11");
    end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule